// File: doc/BRIEF.md
# Energy Pulse Output Timing Generator

This block turns pulse requests from an energy accumulator into three active-low output lines: a primary pulse line, a secondary pulse line and a direction qualifier. It spaces the pulses so that receiving meters and counters can always resolve them. Each pulse line has a fixed low time and a minimum spacing between falling edges. The qualifier is held steady for a set number of cycles before any pulse falls. A fall on the secondary line is held back until a set interval has passed since the latest fall on the primary line.

Every interval is a count of master-clock cycles set by a parameter. The timing therefore scales with the clock, and the block can be moved to another clock rate by changing only the parameters. A request that arrives while its line is still inside its spacing interval is queued and issued later; none is lost. The default parameters suit a 4.096 MHz clock: a period of 2048 cycles, a low time of 1000 cycles, a qualifier setup of 6 cycles and a stagger of 1016 cycles.

Top module: `epg_pulse_gen`

## Requirements
- R1: After reset, both pulse lines and the qualifier are high and busy is low.
- R2: Every pulse on either line stays low for exactly WIDTH_CYC cycles and then returns high.
- R3: Two falling edges on the same pulse line are at least PERIOD_CYC cycles apart. When requests are queued, they are exactly PERIOD_CYC cycles apart.
- R4: Each request strobe produces exactly one pulse on its line, even when it arrives during the line's period. Up to 2^PEND_W-1 requests per line can be held at once.
- R5: A secondary fall comes at least STAGGER_CYC cycles after the latest primary fall. A secondary pulse that is held back by this rule falls exactly STAGGER_CYC cycles after the primary fall. If both streams become eligible in the same cycle, the primary line goes first.
- R6: The qualifier output is the inverse of the direction bit: it is low when the direction bit is 1. While no pulse is low, it follows a change of the direction bit one clock edge after the bit is sampled.
- R7: With the block idle and the qualifier settled, a request driven in one cycle makes its line fall two clock edges later.
- R8: Busy is high while a request is queued or any interval counter is running. After the last pulse, busy drops PERIOD_CYC-1 cycles after that pulse's falling edge. Whenever busy is low, both pulse lines are high.
- R9: A pulse line falls no earlier than SETUP_CYC cycles after the last qualifier change. A request that arrives together with a direction change from idle falls exactly SETUP_CYC cycles after the qualifier changes.
- R10: The qualifier does not change while either pulse line is low. A direction change made during a pulse takes effect one edge after the line returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_a_i | input | 1 | Single-cycle request for one primary pulse |
| req_b_i | input | 1 | Single-cycle request for one secondary pulse |
| dir_i | input | 1 | Direction bit; 1 drives the qualifier low |
| pls_a_n_o | output | 1 | Primary pulse line, active low |
| qual_n_o | output | 1 | Direction qualifier line, low for direction 1 |
| pls_b_n_o | output | 1 | Secondary pulse line, active low |
| busy_o | output | 1 | High while requests are queued or intervals are running |

## Verification
From idle, a request is due on its line two edges after it is driven. Queued pulses follow every PERIOD_CYC cycles. A held-back secondary pulse lands STAGGER_CYC cycles after the primary fall. A request paired with a direction change lands SETUP_CYC cycles after the qualifier moves, and the qualifier itself moves one edge after the direction bit is sampled. The bench keeps a cycle count that advances on each rising edge, and samples every output on the falling edge. It computes each expected cycle number in closed form from the cycle in which the stimulus was driven, and compares it with the falling-edge times that its monitor records. This covers bursts of one to five requests and every offset between the two streams over a window larger than the stagger.

// File: rtl/epg_pkg.sv
package epg_pkg;

    localparam int NUM_LINES = 2;
    localparam int LINE_PRI  = 0;
    localparam int LINE_SEC  = 1;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/epg_pending.sv
module epg_pending #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic has_o
);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({req_i, take_i})
            2'b10: begin
                if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            end
            2'b01: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            end
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign has_o = (st_q.cnt != '0);

endmodule

// File: rtl/epg_channel.sv
module epg_channel #(
    parameter int PERIOD_CYC = 2048,
    parameter int WIDTH_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic pulse_n_o,
    output logic ready_o,
    output logic running_o
);

    localparam int CW = $clog2(PERIOD_CYC);
    localparam logic [CW-1:0] LOAD_V = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] LOW_END = CW'(PERIOD_CYC - WIDTH_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          low;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch_i) begin
            st_d.cnt = LOAD_V;
            st_d.low = 1'b1;
        end else begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.low && (st_q.cnt <= LOW_END)) st_d.low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_n_o = ~st_q.low;
    assign ready_o   = (st_q.cnt == '0);
    assign running_o = (st_q.cnt != '0);

endmodule

// File: rtl/epg_qualifier.sv
module epg_qualifier #(
    parameter int SETUP_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    input  logic hold_i,
    output logic qual_n_o,
    output logic settled_o,
    output logic changing_o
);

    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam logic [SW-1:0] AGE_MAX = SW'(SETUP_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [SW-1:0] age;
    } qual_t;

    qual_t st_d, st_q;
    logic  chg;

    always_comb begin
        st_d = st_q;
        chg  = !hold_i && (dir_i != st_q.lvl);
        if (chg) begin
            st_d.lvl = dir_i;
            st_d.age = '0;
        end else if (st_q.age != AGE_MAX) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
            st_q.age <= AGE_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign qual_n_o   = ~st_q.lvl;
    assign settled_o  = (st_q.age == AGE_MAX);
    assign changing_o = chg;

endmodule

// File: rtl/epg_pulse_gen.sv
module epg_pulse_gen #(
    parameter int PERIOD_CYC  = 2048,
    parameter int WIDTH_CYC   = 1000,
    parameter int SETUP_CYC   = 6,
    parameter int STAGGER_CYC = 1016,
    parameter int PEND_W      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a_i,
    input  logic req_b_i,
    input  logic dir_i,
    output logic pls_a_n_o,
    output logic qual_n_o,
    output logic pls_b_n_o,
    output logic busy_o
);

    import epg_pkg::*;

    localparam int SCW = $clog2(STAGGER_CYC + 1);
    localparam logic [SCW-1:0] STG_LOAD = SCW'(STAGGER_CYC - 1);

    typedef struct packed {
        logic [SCW-1:0] stg;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_LINES-1:0] req;
    logic [NUM_LINES-1:0] has;
    logic [NUM_LINES-1:0] ready;
    logic [NUM_LINES-1:0] running;
    logic [NUM_LINES-1:0] pulse_n;
    logic [NUM_LINES-1:0] launch;
    logic                 settled;
    logic                 changing;
    logic                 any_low;

    assign req[LINE_PRI] = req_a_i;
    assign req[LINE_SEC] = req_b_i;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            epg_pending #(
                .PEND_W(PEND_W)
            ) u_pend (
                .clk   (clk),
                .rst_n (rst_n),
                .req_i (req[g]),
                .take_i(launch[g]),
                .has_o (has[g])
            );

            epg_channel #(
                .PERIOD_CYC(PERIOD_CYC),
                .WIDTH_CYC (WIDTH_CYC)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .launch_i (launch[g]),
                .pulse_n_o(pulse_n[g]),
                .ready_o  (ready[g]),
                .running_o(running[g])
            );
        end
    endgenerate

    assign any_low = ~&pulse_n;

    epg_qualifier #(
        .SETUP_CYC(SETUP_CYC)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_i),
        .hold_i    (any_low),
        .qual_n_o  (qual_n_o),
        .settled_o (settled),
        .changing_o(changing)
    );

    always_comb begin
        st_d = st_q;
        launch[LINE_PRI] = has[LINE_PRI] && ready[LINE_PRI] && settled && !changing;
        launch[LINE_SEC] = has[LINE_SEC] && ready[LINE_SEC] && settled && !changing
                           && (st_q.stg == '0) && !launch[LINE_PRI];
        if (launch[LINE_PRI])    st_d.stg = STG_LOAD;
        else if (st_q.stg != '0) st_d.stg = st_q.stg - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pls_a_n_o = pulse_n[LINE_PRI];
    assign pls_b_n_o = pulse_n[LINE_SEC];
    assign busy_o    = (|has) || (|running) || (st_q.stg != '0);

endmodule

// File: rtl/epg_checker.sv
module epg_checker #(
    parameter int PERIOD_CYC  = 2048,
    parameter int WIDTH_CYC   = 1000,
    parameter int SETUP_CYC   = 6,
    parameter int STAGGER_CYC = 1016
) (
    input logic clk,
    input logic rst_n,
    input logic pls_a_n,
    input logic pls_b_n,
    input logic qual_n,
    input logic busy
);

    localparam int MAXV = epg_pkg::max3(PERIOD_CYC, STAGGER_CYC, SETUP_CYC);
    localparam int CK = $clog2(MAXV + 1);
    localparam logic [CK-1:0] SAT = CK'(MAXV);

    logic          prev_a, prev_b, prev_q;
    logic [CK-1:0] since_a, since_b, since_q, low_a, low_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_a  <= 1'b1;
            prev_b  <= 1'b1;
            prev_q  <= 1'b1;
            since_a <= SAT;
            since_b <= SAT;
            since_q <= SAT;
            low_a   <= '0;
            low_b   <= '0;
        end else begin
            prev_a <= pls_a_n;
            prev_b <= pls_b_n;
            prev_q <= qual_n;
            since_a <= (prev_a && !pls_a_n) ? CK'(1) : ((since_a == SAT) ? SAT : since_a + 1'b1);
            since_b <= (prev_b && !pls_b_n) ? CK'(1) : ((since_b == SAT) ? SAT : since_b + 1'b1);
            since_q <= (prev_q != qual_n)   ? CK'(1) : ((since_q == SAT) ? SAT : since_q + 1'b1);
            low_a <= !pls_a_n ? (prev_a ? CK'(1) : low_a + 1'b1) : '0;
            low_b <= !pls_b_n ? (prev_b ? CK'(1) : low_b + 1'b1) : '0;
        end
    end

    p_width_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pls_a_n) |-> (low_a == CK'(WIDTH_CYC)));
    p_width_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pls_b_n) |-> (low_b == CK'(WIDTH_CYC)));
    p_period_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_a_n) |-> (since_a >= CK'(PERIOD_CYC)));
    p_period_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_b_n) |-> (since_b >= CK'(PERIOD_CYC)));
    p_stagger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_b_n) |-> (since_a >= CK'(STAGGER_CYC)));
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pls_a_n && pls_b_n));
    p_setup_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_a_n) |-> (since_q >= CK'(SETUP_CYC)));
    p_setup_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_b_n) |-> (since_q >= CK'(SETUP_CYC)));
    p_qual_hold_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pls_a_n && !prev_a) |-> $stable(qual_n));
    p_qual_hold_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pls_b_n && !prev_b) |-> $stable(qual_n));

endmodule

bind epg_pulse_gen epg_checker #(
    .PERIOD_CYC (PERIOD_CYC),
    .WIDTH_CYC  (WIDTH_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .STAGGER_CYC(STAGGER_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pls_a_n(pls_a_n_o),
    .pls_b_n(pls_b_n_o),
    .qual_n (qual_n_o),
    .busy   (busy_o)
);

// File: tb/sim_epg_pulse_gen.sv
`timescale 1ns/1ps
module sim_epg_pulse_gen;

    localparam int P  = 20;
    localparam int W  = 8;
    localparam int SU = 3;
    localparam int S  = 9;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, req_b = 1'b0, dir = 1'b0;
    logic pa_n, q_n, pb_n, busy;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int fa[256];
    int fb[256];
    int na = 0, nb = 0;
    int ra = -1, qchg = -1;
    int last_a = -100000, last_b = -100000, last_fall = -100000;
    logic pa_p = 1'b1, pb_p = 1'b1, q_p = 1'b1;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    epg_pulse_gen #(
        .PERIOD_CYC(P), .WIDTH_CYC(W), .SETUP_CYC(SU), .STAGGER_CYC(S), .PEND_W(PW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_a_i(req_a), .req_b_i(req_b), .dir_i(dir),
        .pls_a_n_o(pa_n), .qual_n_o(q_n), .pls_b_n_o(pb_n), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Monitor: records falling edges and checks the timing rules on every event
    always @(negedge clk) begin
        if (rst_n) begin
            if (pa_p && !pa_n) begin
                if (last_a > -100000) chk(cyc - last_a >= P, "R3 primary spacing", cyc - last_a, P);
                if (qchg >= 0) chk(cyc - qchg >= SU, "R9 setup primary", cyc - qchg, SU);
                fa[na % 256] = cyc; na++; last_a = cyc; ra = cyc;
            end
            if (!pa_p && pa_n) chk(cyc - ra == W, "R2 primary width", cyc - ra, W);
            if (pb_p && !pb_n) begin
                if (last_b > -100000) chk(cyc - last_b >= P, "R3 secondary spacing", cyc - last_b, P);
                if (last_a > -100000) chk(cyc - last_a >= S, "R5 stagger", cyc - last_a, S);
                if (qchg >= 0) chk(cyc - qchg >= SU, "R9 setup secondary", cyc - qchg, SU);
                fb[nb % 256] = cyc; nb++; last_b = cyc; last_fall = cyc;
            end
            if (!pb_p && pb_n) chk(cyc - last_fall == W, "R2 secondary width", cyc - last_fall, W);
            if (q_p != q_n) begin
                chk(pa_p && pb_p && pa_n && pb_n, "R10 qualifier moved during pulse",
                    {pa_p, pb_p}, 3);
                qchg = cyc;
            end
            pa_p <= pa_n; pb_p <= pb_n; q_p <= q_n;
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic burst(input bit sec, input int k);
        int t, base, lst;
        t = cyc;
        base = sec ? nb : na;
        for (int i = 0; i < k; i++) begin
            if (sec) req_b = 1'b1; else req_a = 1'b1;
            @(negedge clk);
        end
        req_a = 1'b0; req_b = 1'b0;
        chk(busy == 1'b1, "R8 busy after request", busy, 1);
        lst = t + 2 + (k - 1) * P;
        wait_until(lst + P - 2);
        chk(busy == 1'b1, "R8 busy before final interval end", busy, 1);
        wait_until(lst + P - 1);
        chk(busy == 1'b0, "R8 busy drop", busy, 0);
        repeat (2) @(negedge clk);
        chk(((sec ? nb : na) - base) == k, "R4 pulse count", (sec ? nb : na) - base, k);
        for (int i = 0; i < k; i++) begin
            int got;
            got = sec ? fb[(base + i) % 256] : fa[(base + i) % 256];
            if (i == 0) chk(got == t + 2, "R7 first fall latency", got, t + 2);
            else        chk(got == t + 2 + i * P, "R3 queued spacing", got, t + 2 + i * P);
        end
    endtask

    task automatic pair(input int d);
        int start, ta, tb, fa_e, fb_e, ba, bb, hi;
        start = cyc;
        ta = start + ((d < 0) ? -d : 0);
        tb = start + ((d < 0) ? 0 : d);
        hi = (ta > tb) ? ta : tb;
        ba = na; bb = nb;
        while (cyc <= hi) begin
            req_a = (cyc == ta);
            req_b = (cyc == tb);
            @(negedge clk);
        end
        req_a = 1'b0; req_b = 1'b0;
        wait_idle();
        fa_e = ta + 2;
        if (tb + 2 < fa_e)            fb_e = tb + 2;
        else if (tb + 2 >= fa_e + S)  fb_e = tb + 2;
        else                          fb_e = fa_e + S;
        chk(fa[ba % 256] == fa_e, "R7 primary fall in pair", fa[ba % 256], fa_e);
        chk(fb[bb % 256] == fb_e, "R5 secondary fall vs stagger", fb[bb % 256], fb_e);
    endtask

    initial begin
        int t, f, base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(pa_n == 1'b1, "R1 primary idle", pa_n, 1);
        chk(pb_n == 1'b1, "R1 secondary idle", pb_n, 1);
        chk(q_n == 1'b1, "R1 qualifier idle", q_n, 1);
        chk(busy == 1'b0, "R1 busy idle", busy, 0);

        // R2 R3 R4 R7 R8: bursts on each line
        for (int k = 1; k <= 5; k++) begin
            burst(1'b0, k);
            wait_idle();
        end
        for (int k = 1; k <= 3; k++) begin
            burst(1'b1, k);
            wait_idle();
        end

        // R5: sweep of offsets between the two streams
        for (int d = -3; d <= S + 5; d++) pair(d);

        // R6 R9: direction change together with a request from idle
        t = cyc; base = na;
        dir = 1'b1; req_a = 1'b1;
        @(negedge clk);
        req_a = 1'b0;
        chk(q_n == 1'b0, "R6 qualifier follows direction", q_n, 0);
        wait_until(t + SU);
        chk(pa_n == 1'b1, "R9 pulse held for setup", pa_n, 1);
        wait_idle();
        chk(fa[base % 256] == t + SU + 1, "R9 fall after setup", fa[base % 256], t + SU + 1);

        // R10: direction change during a low pulse is deferred
        t = cyc; base = na;
        req_a = 1'b1;
        @(negedge clk);
        req_a = 1'b0;
        f = t + 2;
        wait_until(f + 2);
        dir = 1'b0;
        wait_until(f + W);
        chk(fa[base % 256] == f, "R7 fall with direction 1", fa[base % 256], f);
        chk(q_n == 1'b0, "R10 qualifier held at pulse end", q_n, 0);
        chk(pa_n == 1'b1, "R2 pulse released", pa_n, 1);
        wait_until(f + W + 1);
        chk(q_n == 1'b1, "R6 qualifier updates after pulse", q_n, 1);
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule